// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two operands held in signed-magnitude form. The most significant bit of each operand is its sign, where 0 is positive and 1 is negative. The lower bits are an unsigned magnitude.

A caller presents both operands and an add/subtract command together with a one-cycle `start_i` pulse while the block is idle. A small sequencer then steps the datapath through three phases:

- **Load** captures the operands.
- **Arithmetic** uses a single parallel adder behind a controlled complementer. It forms either the magnitude sum or the difference A + ~B + 1, and the adder's carry-out is kept as a magnitude comparison.
- **Fix-up** negates a borrowed difference, flips the sign, and removes negative zero.

The signed result and an overflow flag stay on the outputs until the next accepted start. A one-cycle `done_o` pulse marks the moment they become valid.

Top module: `sm_addsub`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first operation, `result_o` is 0, `ovf_o` is 0, and `busy_o` and `done_o` are 0.
- R2: Effective addition occurs for an add with equal operand signs, or a subtract with unequal signs. Its result magnitude is the sum of the two magnitudes, and its sign is the sign of operand A.
- R3: On effective addition, `ovf_o` is 1 exactly when the magnitude sum does not fit in WIDTH-1 bits. The result magnitude is then the low WIDTH-1 bits of the sum.
- R4: Effective subtraction occurs for an add with unequal signs, or a subtract with equal signs. When |A| >= |B|, the result magnitude is |A| - |B| and the sign is the sign of A.
- R5: On effective subtraction with |A| < |B|, the result magnitude is |B| - |A| and the sign is the inverse of A's sign.
- R6: A result whose magnitude is zero always has sign bit 0.
- R7: `ovf_o` is 0 after every effective subtraction.
- R8: If `start_i` is sampled high at an idle clock edge, the following hold:
  - `busy_o` is high from that edge.
  - `done_o` is high for exactly the one cycle that follows the third edge, counting the start edge as the first.
  - `busy_o` falls at the fourth edge.
- R9: `start_i` is ignored while `busy_o` is high. Operands presented then do not change the result of the running operation.
- R10: Outside an operation, `result_o` and `ovf_o` hold their last values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| sub_i | input | 1 | 0 = A + B, 1 = A - B |
| a_i | input | WIDTH | Operand A, sign in bit WIDTH-1 |
| b_i | input | WIDTH | Operand B, sign in bit WIDTH-1 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | WIDTH | Signed-magnitude result |
| ovf_o | output | 1 | Magnitude overflow of an effective addition |

## Verification
Take the edge that samples `start_i` as edge 1.

- `busy_o` is due right after edge 1.
- `done_o`, `result_o` and `ovf_o` are due right after edge 3.
- `busy_o` is due to drop after edge 4.

The bench's reference model counts the same edges from the accepted start. It updates its expected result at edge 3, and compares busy and done on every falling edge. It compares result and overflow only in the done cycle and in idle cycles, because in the middle phases those registers legitimately carry intermediate values. Starts issued in the middle phases are ignored by the model's counter, so a design that accepts them is caught at its next done cycle.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARITH = 2'd1,
    ST_FIX   = 2'd2,
    ST_DONE  = 2'd3
  } sm_state_e;
endpackage

// File: rtl/sm_complementer.sv
module sm_complementer #(
  parameter int unsigned N = 7
) (
  input  logic         inv_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign q_o[i] = d_i[i] ^ inv_i;
  end
endmodule

// File: rtl/sm_adder.sv
module sm_adder #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N:0] c;
  assign c[0] = cin_i;
  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ c[i];
    assign c[i+1]   = (x_i[i] & y_i[i]) | (c[i] & (x_i[i] ^ y_i[i]));
  end
  assign cout_o = c[N];
endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl
  import sm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic arith_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  sm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ARITH;
      ST_ARITH: state_d = ST_FIX;
      ST_FIX:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign arith_o = (state_q == ST_ARITH);
  assign fix_o   = (state_q == ST_FIX);
  assign done_o  = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);

  AST_DONE_AFTER_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_o |=> done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R8
  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arith_o, fix_o, done_o})); // R8
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o
);
  localparam int unsigned MAG_W = WIDTH - 1;

  logic             load, arith, fix;
  logic [MAG_W-1:0] a_q, b_q;
  logic             as_q, bs_q, e_q, avf_q, esub_q;
  logic [MAG_W-1:0] add_x, add_y, add_y_c, sum;
  logic             mode_m, cout;

  sm_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .arith_o (arith),
    .fix_o   (fix),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // fix-up reuses the adder: 0 + ~A + 1 = -A
  always_comb begin
    if (fix) begin
      add_x  = '0;
      add_y  = a_q;
      mode_m = 1'b1;
    end else begin
      add_x  = a_q;
      add_y  = b_q;
      mode_m = as_q ^ bs_q;
    end
  end

  sm_complementer #(.N(MAG_W)) i_comp (
    .inv_i (mode_m),
    .d_i   (add_y),
    .q_o   (add_y_c)
  );

  sm_adder #(.N(MAG_W)) i_add (
    .x_i    (add_x),
    .y_i    (add_y_c),
    .cin_i  (mode_m),
    .sum_o  (sum),
    .cout_o (cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      as_q   <= 1'b0;
      bs_q   <= 1'b0;
      e_q    <= 1'b0;
      avf_q  <= 1'b0;
      esub_q <= 1'b0;
    end else if (load) begin
      a_q   <= a_i[MAG_W-1:0];
      b_q   <= b_i[MAG_W-1:0];
      as_q  <= a_i[WIDTH-1];
      bs_q  <= b_i[WIDTH-1] ^ sub_i;
      avf_q <= 1'b0;
    end else if (arith) begin
      esub_q <= mode_m;
      a_q    <= sum;
      e_q    <= cout;
      avf_q  <= mode_m ? 1'b0 : cout;
    end else if (fix) begin
      if (a_q == '0) begin
        as_q <= 1'b0;
      end else if (esub_q && !e_q) begin
        a_q  <= sum;
        as_q <= ~as_q;
      end
    end
  end

  assign result_o = {as_q, a_q};
  assign ovf_o    = avf_q;

  AST_NO_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (a_q == '0)) |-> !as_q); // R6
  AST_SUB_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && esub_q) |-> !ovf_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(ovf_o))); // R10
  AST_BUSY_OPERAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(b_q)); // R9
endmodule

// File: tb/test_sm_addsub.sv
module test_sm_addsub;
  localparam int W   = 8;
  localparam int MW  = W - 1;
  localparam int MOD = 1 << MW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sub = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         busy, done, ovf;
  logic [W-1:0] res;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  sm_addsub #(.WIDTH(W)) i_sm_addsub (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done),
    .result_o(res), .ovf_o(ovf)
  );

  // reference model state
  int           m_cnt = 0;
  logic [W-1:0] m_res = '0, p_res = '0;
  logic         m_ovf = 1'b0, p_ovf = 1'b0;
  string        m_tag = "R1", p_tag = "R1";
  logic         m_ign = 1'b0;

  task automatic reference(input logic [W-1:0] ra, input logic [W-1:0] rb, input logic rs);
    int sa, sb, ma, mb, mag, sg;
    sa = ra[W-1]; sb = rb[W-1] ^ rs;
    ma = ra[MW-1:0]; mb = rb[MW-1:0];
    if (sa == sb) begin
      mag = ma + mb;
      p_ovf = (mag >= MOD);
      mag = mag % MOD;
      sg = sa;
      p_tag = p_ovf ? "R3" : (mag == 0 ? "R6" : "R2");
    end else begin
      p_ovf = 1'b0;
      if (ma >= mb) begin mag = ma - mb; sg = sa; p_tag = "R4 R7"; end
      else          begin mag = mb - ma; sg = sb; p_tag = "R5 R7"; end
      if (mag == 0) p_tag = "R6 R7";
    end
    if (mag == 0) sg = 0;
    p_res = W'((sg << MW) | mag);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_res = '0; m_ovf = 1'b0; m_tag = "R1"; m_ign = 1'b0;
    end else if (m_cnt == 0) begin
      if (start) begin
        reference(a, b, sub);
        m_cnt = 3; m_ign = 1'b0;
      end
    end else begin
      if (start) m_ign = 1'b1;
      m_cnt = m_cnt - 1;
      if (m_cnt == 1) begin
        m_res = p_res; m_ovf = p_ovf;
        m_tag = m_ign ? {p_tag, " R9"} : p_tag;
      end else if (m_cnt == 0) begin
        m_tag = "R10";
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1", "result in reset", int'(res), 0);
      check("R1", "busy in reset", int'(busy), 0);
    end else begin
      check("R8", "busy", int'(busy), int'(m_cnt != 0));
      check("R8", "done", int'(done), int'(m_cnt == 1));
      if (m_cnt <= 1) begin
        check(m_tag, "result", int'(res), int'(m_res));
        check(m_tag, "overflow", int'(ovf), int'(m_ovf));
      end
    end
  end

  task automatic op(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xs);
    @(negedge clk);
    a = xa; b = xb; sub = xs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = '0; b = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op(8'h05, 8'h03, 1'b0);  // R2 +5 + +3
    op(8'h85, 8'h83, 1'b0);  // R2 -5 + -3
    op(8'h05, 8'h03, 1'b1);  // R4 +5 - +3
    op(8'h03, 8'h05, 1'b1);  // R5 +3 - +5
    op(8'h83, 8'h85, 1'b1);  // R5 -3 - -5
    op(8'h64, 8'h64, 1'b0);  // R3 100 + 100
    op(8'h40, 8'h40, 1'b0);  // R3 wraps to zero
    op(8'h07, 8'h07, 1'b1);  // R6 +7 - +7
    op(8'h87, 8'h07, 1'b0);  // R6 -7 + +7
    op(8'h80, 8'h80, 1'b0);  // R6 -0 + -0
    op(8'hE4, 8'h64, 1'b1);  // R3 -100 - +100
    op(8'h01, 8'hFF, 1'b0);  // R5 +1 + -127
    op(8'h7F, 8'h7F, 1'b0);  // R3 then R7 below
    op(8'h7F, 8'h01, 1'b1);  // R7 clears flag
    // R9: starts during busy with other operands
    @(negedge clk);
    a = 8'h11; b = 8'h22; sub = 1'b0; start = 1'b1;
    @(negedge clk);
    a = 8'h7F; b = 8'h7F; sub = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);  // R10 idle hold
    for (int i = 0; i < 300; i++) begin
      op(W'($urandom), W'($urandom), 1'($urandom));
      if (i % 7 == 0) repeat (2) @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule